// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one output compare channel with its own 16-bit up-counter. A CPU programs it over an 8-bit register bus. A timer tick input advances the counter. On each tick the counter is compared with the active compare value. A hit raises a sticky match flag and acts on an output pin in one of four ways: hold, toggle, drive low or drive high. A one-bit select chooses PWM or non-PWM operation. In PWM operation the counter wraps at a TOP value given on an input port. Compare values written in that mode wait in a buffer and become active at TOP. In non-PWM operation they become active at once.

The CPU writes 16-bit values as two bytes, upper byte first. The upper byte goes into one shared staging byte. The lower byte write then commits both halves in a single clock. In non-PWM operation a force strobe acts on the pin as a hit would, with no other side effect. Any CPU write to the counter suppresses matching until the next tick has passed.

Top module: `oc_compare_unit`

## Requirements
- R1: After reset the counter, compare value, buffer, control, match flag and pin all read as zero.
- R2: Each cycle with tick high and no counter write adds one to the counter. In non-PWM it wraps from 0xFFFF to 0. In PWM, a tick with the counter equal to `top_i` loads 0.
- R3: Address 3 (compare upper byte) and address 1 (counter upper byte) only load the shared staging byte. Writing address 2 commits {staging, data} as the compare value in one cycle. Addresses 2 and 3 read the last committed value directly.
- R4: In non-PWM mode (control bit 0 = 0), a committed compare value is used for matching from the next cycle on.
- R5: In PWM mode (control bit 0 = 1), a committed compare value is only buffered. It becomes active on the tick where the counter equals `top_i`. Until then, matching uses the previous value.
- R6: A tick with counter equal to the active compare value sets the match flag and acts on the pin at that edge. The action follows control bits 2:1: 00 hold, 01 toggle, 10 low, 11 high.
- R7: Writing address 5 with bit 0 = 1 clears the match flag, and bit 0 = 0 leaves it unchanged. A match in the same cycle wins over the clear.
- R8: A control write (address 4) with bit 3 = 1 and bit 0 = 0 acts on the pin as a match would, using the written mode bits. It leaves the flag and counter untouched. Bit 3 always reads as 0.
- R9: The force bit has no effect when the written bit 0 is 1 (PWM).
- R10: A counter write (address 0 commits {staging, data}) suppresses any match in its own cycle and at the next tick, however many idle cycles come between them.
- R11: Mode bits written in the same cycle as a match decide that match's pin action.
- R12: A force and a real match in the same cycle produce a single pin action, and the flag is set.
- R13: The pin keeps its value when the PWM select changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timer tick; advances counter and enables compare |
| top_i | input | 16 | Wrap value in PWM mode |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| count_o | output | 16 | Current counter value |
| match_flag_o | output | 1 | Sticky match flag |
| oc_pin_o | output | 1 | Compare output pin |

## Verification
A force strobe and a real compare hit can land on the same clock edge. The bench provokes this by loading the counter one below the compare value and ticking once. On the following tick it writes the control register with the force bit and toggle mode. A double toggle would leave the pin unchanged, so only one toggle counts as correct, and the flag must also be set. The same pattern checks that a flag clear loses to a hit, and that mode bits written during a hit decide its action. A behavioural model runs beside the design and compares counter, flag and pin every cycle.

// File: rtl/oc_pkg.sv
package oc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CNT_LO = 3'd0,
    REG_CNT_HI = 3'd1,
    REG_CMP_LO = 3'd2,
    REG_CMP_HI = 3'd3,
    REG_CTRL   = 3'd4,
    REG_FLAG   = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    PIN_HOLD   = 2'b00,
    PIN_TOGGLE = 2'b01,
    PIN_LOW    = 2'b10,
    PIN_HIGH   = 2'b11
  } pin_act_e;

  localparam int CTL_PWM   = 0;
  localparam int CTL_ACT_L = 1;
  localparam int CTL_ACT_H = 2;
  localparam int CTL_FORCE = 3;
endpackage

// File: rtl/oc_counter.sv
module oc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             pwm_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             at_top_o,
  output logic             block_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             blk_q, blk_d;
  logic             wrap;

  assign wrap     = pwm_i && (cnt_q == top_i);
  assign at_top_o = tick_i && wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (tick_i) begin
      cnt_d = wrap ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    blk_d = blk_q;
    if (load_i) begin
      blk_d = 1'b1;
    end else if (tick_i) begin
      blk_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      blk_q <= blk_d;
    end
  end

  assign count_o = cnt_q;
  assign block_o = blk_q;
endmodule

// File: rtl/oc_regif.sv
module oc_regif
  import oc_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic             wr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  input  logic [CNT_W-1:0] count_i,
  input  logic             flag_i,
  input  logic             at_top_i,
  output logic             pwm_o,
  output pin_act_e         act_eff_o,
  output logic             force_o,
  output logic             flag_clr_o,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_val_o,
  output logic [CNT_W-1:0] cmp_o
);
  logic             wr_cnt_lo, wr_cnt_hi, wr_cmp_lo, wr_cmp_hi, wr_ctrl, wr_flag;
  logic [BUS_W-1:0] stage_q, stage_d;
  logic [CNT_W-1:0] buf_q, buf_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic             pwm_q, pwm_d;
  pin_act_e         mode_q, mode_d;
  logic [CNT_W-1:0] joined;

  assign wr_cnt_lo = wr_i && (addr_i == REG_CNT_LO);
  assign wr_cnt_hi = wr_i && (addr_i == REG_CNT_HI);
  assign wr_cmp_lo = wr_i && (addr_i == REG_CMP_LO);
  assign wr_cmp_hi = wr_i && (addr_i == REG_CMP_HI);
  assign wr_ctrl   = wr_i && (addr_i == REG_CTRL);
  assign wr_flag   = wr_i && (addr_i == REG_FLAG);

  assign joined = {stage_q, wdata_i};

  always_comb begin
    stage_d = stage_q;
    if (wr_cnt_hi || wr_cmp_hi) begin
      stage_d = wdata_i;
    end
  end

  always_comb begin
    buf_d = buf_q;
    act_d = act_q;
    if (wr_cmp_lo) begin
      buf_d = joined;
    end
    if (wr_cmp_lo && !pwm_q) begin
      act_d = joined;
    end else if (at_top_i) begin
      act_d = buf_q;
    end
  end

  always_comb begin
    pwm_d  = pwm_q;
    mode_d = mode_q;
    if (wr_ctrl) begin
      pwm_d  = wdata_i[CTL_PWM];
      mode_d = pin_act_e'(wdata_i[CTL_ACT_H:CTL_ACT_L]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      buf_q   <= '0;
      act_q   <= '0;
      pwm_q   <= 1'b0;
      mode_q  <= PIN_HOLD;
    end else begin
      stage_q <= stage_d;
      buf_q   <= buf_d;
      act_q   <= act_d;
      pwm_q   <= pwm_d;
      mode_q  <= mode_d;
    end
  end

  assign act_eff_o  = wr_ctrl ? pin_act_e'(wdata_i[CTL_ACT_H:CTL_ACT_L]) : mode_q;
  assign force_o    = wr_ctrl && wdata_i[CTL_FORCE] && !wdata_i[CTL_PWM];
  assign flag_clr_o = wr_flag && wdata_i[0];
  assign cnt_load_o = wr_cnt_lo;
  assign cnt_val_o  = joined;
  assign cmp_o      = act_q;
  assign pwm_o      = pwm_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CNT_LO: rdata_o = count_i[BUS_W-1:0];
      REG_CNT_HI: rdata_o = count_i[CNT_W-1:BUS_W];
      REG_CMP_LO: rdata_o = buf_q[BUS_W-1:0];
      REG_CMP_HI: rdata_o = buf_q[CNT_W-1:BUS_W];
      REG_CTRL: begin
        rdata_o[CTL_PWM]             = pwm_q;
        rdata_o[CTL_ACT_H:CTL_ACT_L] = mode_q;
      end
      REG_FLAG:   rdata_o[0] = flag_i;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/oc_waveform.sv
module oc_waveform
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             block_i,
  input  logic             load_i,
  input  pin_act_e         act_i,
  input  logic             force_i,
  input  logic             flag_clr_i,
  output logic             flag_o,
  output logic             pin_o
);
  logic hit;
  logic fire;
  logic flag_q, flag_d;
  logic pin_q, pin_d;

  assign hit  = tick_i && (count_i == cmp_i) && !block_i && !load_i;
  assign fire = hit || force_i;

  always_comb begin
    flag_d = flag_q;
    if (hit) begin
      flag_d = 1'b1;
    end else if (flag_clr_i) begin
      flag_d = 1'b0;
    end
  end

  always_comb begin
    pin_d = pin_q;
    if (fire) begin
      case (act_i)
        PIN_TOGGLE: pin_d = !pin_q;
        PIN_LOW:    pin_d = 1'b0;
        PIN_HIGH:   pin_d = 1'b1;
        default:    pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      pin_q  <= pin_d;
    end
  end

  assign flag_o = flag_q;
  assign pin_o  = pin_q;
endmodule

// File: rtl/oc_compare_unit.sv
module oc_compare_unit
  import oc_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic [2*BUS_W-1:0]   top_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic                 bus_wr_i,
  input  logic [BUS_W-1:0]     bus_wdata_i,
  output logic [BUS_W-1:0]     bus_rdata_o,
  output logic [2*BUS_W-1:0]   count_o,
  output logic                 match_flag_o,
  output logic                 oc_pin_o
);
  localparam int CNT_W = 2 * BUS_W;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = sync_q[SYNC_STAGES-1];

  logic             pwm_q;
  pin_act_e         act_eff;
  logic             force_fire;
  logic             flag_clr;
  logic             cnt_wr;
  logic [CNT_W-1:0] cnt_wdata;
  logic [CNT_W-1:0] cmp_active;
  logic             at_top;
  logic             block_pend;

  oc_regif #(.BUS_W(BUS_W), .CNT_W(CNT_W)) regif_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .addr_i     (bus_addr_i),
    .wr_i       (bus_wr_i),
    .wdata_i    (bus_wdata_i),
    .rdata_o    (bus_rdata_o),
    .count_i    (count_o),
    .flag_i     (match_flag_o),
    .at_top_i   (at_top),
    .pwm_o      (pwm_q),
    .act_eff_o  (act_eff),
    .force_o    (force_fire),
    .flag_clr_o (flag_clr),
    .cnt_load_o (cnt_wr),
    .cnt_val_o  (cnt_wdata),
    .cmp_o      (cmp_active)
  );

  oc_counter #(.CNT_W(CNT_W)) counter_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_i     (tick_i),
    .pwm_i      (pwm_q),
    .top_i      (top_i),
    .load_i     (cnt_wr),
    .load_val_i (cnt_wdata),
    .count_o    (count_o),
    .at_top_o   (at_top),
    .block_o    (block_pend)
  );

  oc_waveform #(.CNT_W(CNT_W)) wave_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_i     (tick_i),
    .count_i    (count_o),
    .cmp_i      (cmp_active),
    .block_i    (block_pend),
    .load_i     (cnt_wr),
    .act_i      (act_eff),
    .force_i    (force_fire),
    .flag_clr_i (flag_clr),
    .flag_o     (match_flag_o),
    .pin_o      (oc_pin_o)
  );
endmodule

// File: rtl/oc_compare_chk.sv
module oc_compare_chk #(
  parameter int BUS_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             pwm_q,
  input logic             cnt_wr,
  input logic             block_pend,
  input logic             force_fire,
  input logic             flag_clr,
  input logic             bus_wr,
  input logic [2:0]       bus_addr,
  input logic [BUS_W-1:0] bus_wdata,
  input logic [CNT_W-1:0] count,
  input logic             flag,
  input logic             pin
);
  // R2: free-running step in non-PWM mode
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pwm_q && !cnt_wr) |=> (count == $past(count) + CNT_W'(1)));

  // R10: a pending block keeps the flag from rising at the next tick
  p_block_no_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && block_pend && !flag) |=> !flag);

  // R7: clear without a concurrent tick leaves the flag low
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !tick) |=> !flag);

  // R8: force touches neither flag nor counter
  p_force_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (force_fire && !tick) |=> ($stable(flag) && $stable(count)));

  // R9: force bit written together with PWM select leaves the pin alone
  p_pwm_force_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd4 && bus_wdata[0] && bus_wdata[3] && !tick) |=> $stable(pin));
endmodule

bind oc_compare_unit oc_compare_chk #(.BUS_W(BUS_W), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .tick       (tick_i),
  .pwm_q      (pwm_q),
  .cnt_wr     (cnt_wr),
  .block_pend (block_pend),
  .force_fire (force_fire),
  .flag_clr   (flag_clr),
  .bus_wr     (bus_wr_i),
  .bus_addr   (bus_addr_i),
  .bus_wdata  (bus_wdata_i),
  .count      (count_o),
  .flag       (match_flag_o),
  .pin        (oc_pin_o)
);

// File: tb/oc_compare_unit_tb_top.sv
`timescale 1ns/1ps
module oc_compare_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic        tick_i;
  logic [15:0] top_i;
  logic [2:0]  bus_addr_i;
  logic        bus_wr_i;
  logic [7:0]  bus_wdata_i;
  logic [7:0]  bus_rdata_o;
  logic [15:0] count_o;
  logic        match_flag_o;
  logic        oc_pin_o;

  int n_chk = 0;
  int n_bad = 0;
  bit mdl_en = 0;

  // behavioural reference state
  int m_cnt = 0, m_act = 0, m_buf = 0, m_stg = 0, m_mode = 0;
  bit m_pwm = 0, m_flag = 0, m_pin = 0, m_blk = 0;

  oc_compare_unit dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .top_i        (top_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wr_i     (bus_wr_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_rdata_o  (bus_rdata_o),
    .count_o      (count_o),
    .match_flag_o (match_flag_o),
    .oc_pin_o     (oc_pin_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int m_read(input int a);
    case (a)
      0: return m_cnt & 255;
      1: return (m_cnt >> 8) & 255;
      2: return m_buf & 255;
      3: return (m_buf >> 8) & 255;
      4: return (m_mode << 1) | int'(m_pwm);
      5: return int'(m_flag);
      default: return 0;
    endcase
  endfunction

  // reference model: advances from the inputs present at each rising edge
  always @(posedge clk) begin
    if (mdl_en) begin
      int  a, d, joined, mode_use, n_cnt, n_act;
      bit  wr, cload, frc, hit;
      wr = bus_wr_i; a = int'(bus_addr_i); d = int'(bus_wdata_i);
      joined   = (m_stg << 8) | d;
      cload    = wr && a == 0;
      mode_use = (wr && a == 4) ? ((d >> 1) & 3) : m_mode;
      frc      = wr && a == 4 && d[3] && !d[0];
      hit      = tick_i && (m_cnt == m_act) && !m_blk && !cload;
      if (hit || frc) begin
        if (mode_use == 1) m_pin = !m_pin;
        else if (mode_use == 2) m_pin = 0;
        else if (mode_use == 3) m_pin = 1;
      end
      if (hit) m_flag = 1;
      else if (wr && a == 5 && d[0]) m_flag = 0;
      n_cnt = m_cnt;
      if (cload) n_cnt = joined;
      else if (tick_i) n_cnt = (m_pwm && m_cnt == int'(top_i)) ? 0 : ((m_cnt + 1) & 16'hFFFF);
      n_act = m_act;
      if (wr && a == 2 && !m_pwm) n_act = joined;
      else if (tick_i && m_pwm && m_cnt == int'(top_i)) n_act = m_buf;
      if (wr && a == 2) m_buf = joined;
      if (cload) m_blk = 1;
      else if (tick_i) m_blk = 0;
      if (wr && (a == 1 || a == 3)) m_stg = d;
      if (wr && a == 4) begin m_pwm = d[0]; m_mode = (d >> 1) & 3; end
      m_cnt = n_cnt;
      m_act = n_act;
    end
  end

  task automatic ck(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (mdl_en) begin
      ck("R2 counter", int'(count_o), m_cnt);
      ck("R6 flag", int'(match_flag_o), int'(m_flag));
      ck("R6 pin", int'(oc_pin_o), int'(m_pin));
    end
  end

  task automatic step(input bit tk, input bit wr, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    tick_i = tk; bus_wr_i = wr; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk); #1;
    tick_i = 1'b0; bus_wr_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step(1'b0, 1'b1, a, d);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 3'd0, 8'd0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 3'd0, 8'd0);
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input int exp);
    bus_addr_i = a; bus_wr_i = 1'b0;
    #1;
    ck(tag, int'(bus_rdata_o), exp);
    ck({tag, " model"}, int'(bus_rdata_o), m_read(int'(a)));
  endtask

  task automatic set_cnt(input int v);
    wr(3'd1, 8'((v >> 8) & 255));
    wr(3'd0, 8'(v & 255));
  endtask

  task automatic set_cmp(input int v);
    wr(3'd3, 8'((v >> 8) & 255));
    wr(3'd2, 8'(v & 255));
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; top_i = 16'h0020;
    bus_addr_i = '0; bus_wr_i = 1'b0; bus_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    ck("R1 count", int'(count_o), 0);
    ck("R1 flag", int'(match_flag_o), 0);
    ck("R1 pin", int'(oc_pin_o), 0);
    rd("R1 ctrl", 3'd4, 0);
    rd("R1 cmp", 3'd2, 0);
    mdl_en = 1;

    // R3 staged upper byte does not change the compare value on its own
    wr(3'd4, 8'h06);                 // non-PWM, drive high
    wr(3'd3, 8'h12);
    rd("R3 hi-only", 3'd3, 8'h00);
    wr(3'd2, 8'h34);
    rd("R3 commit hi", 3'd3, 8'h12);
    rd("R3 commit lo", 3'd2, 8'h34);
    set_cmp(5);

    // R4/R6 direct compare in non-PWM, set action
    ticks(10);
    ck("R4 flag after direct compare", int'(match_flag_o), 1);
    ck("R6 set pin", int'(oc_pin_o), 1);
    ck("R2 count", int'(count_o), 10);

    // R7 flag clear
    wr(3'd5, 8'h00);
    ck("R7 zero write keeps flag", int'(match_flag_o), 1);
    wr(3'd5, 8'h01);
    ck("R7 clear", int'(match_flag_o), 0);

    // R6 toggle
    wr(3'd4, 8'h02);
    set_cnt(3);
    ticks(3);
    ck("R6 toggle pin", int'(oc_pin_o), 0);
    ck("R6 toggle flag", int'(match_flag_o), 1);

    // R10 counter write equal to compare, long idle before the tick
    wr(3'd5, 8'h01);
    set_cnt(5);
    idle(10);
    ticks(1);
    ck("R10 blocked flag", int'(match_flag_o), 0);
    ck("R10 blocked pin", int'(oc_pin_o), 0);
    step(1'b1, 1'b1, 3'd0, 8'h05);   // counter write during a tick
    ticks(1);
    ck("R10 blocked same-cycle", int'(match_flag_o), 0);

    // R8 force toggles pin only
    wr(3'd4, 8'h0A);
    ck("R8 force pin", int'(oc_pin_o), 1);
    ck("R8 force flag", int'(match_flag_o), 0);
    ck("R8 force count", int'(count_o), 6);
    rd("R8 force reads zero", 3'd4, 8'h02);

    // R11 mode bits written with the hit decide its action
    set_cnt(4);
    ticks(1);
    step(1'b1, 1'b1, 3'd4, 8'h04);
    ck("R11 immediate mode", int'(oc_pin_o), 0);
    rd("R11 ctrl", 3'd4, 8'h04);

    // R12 force and hit together toggle once
    wr(3'd5, 8'h01);
    wr(3'd4, 8'h0A);                  // pin -> 1
    set_cnt(4);
    ticks(1);
    step(1'b1, 1'b1, 3'd4, 8'h0A);
    ck("R12 single toggle", int'(oc_pin_o), 0);
    ck("R12 flag", int'(match_flag_o), 1);

    // R7 hit beats clear
    wr(3'd5, 8'h01);
    set_cnt(4);
    ticks(1);
    step(1'b1, 1'b1, 3'd5, 8'h01);
    ck("R7 set wins", int'(match_flag_o), 1);

    // R2 wrap at 0xFFFF
    set_cnt(16'hFFFE);
    ticks(2);
    ck("R2 wrap", int'(count_o), 0);
    ticks(1);

    // R5 PWM buffering, value becomes active at top
    wr(3'd4, 8'h07);
    wr(3'd5, 8'h01);
    set_cmp(16'h0010);
    rd("R3 buffered read", 3'd2, 8'h10);
    set_cnt(0);
    ticks(6);
    ck("R5 old value still active", int'(match_flag_o), 1);
    ck("R5 set pin", int'(oc_pin_o), 1);
    wr(3'd5, 8'h01);
    wr(3'd4, 8'h05);
    ticks(26);
    ck("R2 at top", int'(count_o), 16'h0020);
    ticks(1);
    ck("R2 pwm wrap", int'(count_o), 0);
    ticks(16);
    ck("R5 no early match", int'(match_flag_o), 0);
    ticks(1);
    ck("R5 new value active", int'(match_flag_o), 1);
    ck("R5 clear pin", int'(oc_pin_o), 0);

    // R9 and R13
    wr(3'd4, 8'h0E);                  // non-PWM force high
    ck("R8 force high", int'(oc_pin_o), 1);
    wr(3'd4, 8'h0B);                  // PWM toggle with force bit
    ck("R9 force ignored", int'(oc_pin_o), 1);
    rd("R9 ctrl", 3'd4, 8'h03);
    wr(3'd4, 8'h00);
    ck("R13 pin kept leaving PWM", int'(oc_pin_o), 1);
    wr(3'd4, 8'h01);
    ck("R13 pin kept entering PWM", int'(oc_pin_o), 1);

    idle(2);
    finish_run();
  end
endmodule